// File: doc/BRIEF.md
# In-Order Retire Slot Queue

This block is the retirement stage of an out-of-order core. It is a circular queue of a fixed number of slots. At dispatch, an instruction claims a run of adjacent slots whose length follows its micro-op count, and it receives a token. The token is the slot number where the run starts. Execution units later report completion by presenting that token. On every clock edge the queue releases finished instructions from its oldest end, strictly in program order. It releases at most a fixed number per cycle, and it emits one retired event per released instruction carrying that instruction's index.

Before claiming slots, the dispatch stage checks the ready signal and the free-slot count. The oldest-first retired lanes feed the logic that frees rename registers.

A small occupancy state machine tracks the fill level and drives the empty and full flags. It has three states: OCC_EMPTY, OCC_PARTIAL and OCC_FULL. Its named transitions are:
- fill_start: OCC_EMPTY to OCC_PARTIAL.
- fill_whole: OCC_EMPTY to OCC_FULL.
- fill_last: OCC_PARTIAL to OCC_FULL.
- drain_last: OCC_PARTIAL to OCC_EMPTY.
- drain_some: OCC_FULL to OCC_PARTIAL.
- drain_whole: OCC_FULL to OCC_EMPTY.
- hold: the state does not change.

Top module: `rsq_retire_queue`

## Requirements
- R1: After reset the queue holds no entries. free_slots equals SLOTS, q_empty is 1, q_full is 0, every ret_valid bit is 0 and rsv_token is 0.
- R2: The number of slots an accepted reservation takes is its rsv_uops value, limited to at most SLOTS. A value of 0 takes exactly one slot.
- R3: rsv_token shows the current tail slot. An accepted reservation moves the tail forward by its slot count, wrapping modulo SLOTS.
- R4: rsv_ready is 1 exactly when the limited slot count is no larger than free_slots. When rsv_valid is high while rsv_ready is low, the reservation is dropped and no slot is taken.
- R5: Retirement starts only at the head and goes in program order. It stops at the first entry whose executed flag is clear, so a younger entry that has executed waits behind an older one that has not.
- R6: An executed mark whose exe_token is not the first slot of a live entry is ignored. This covers an interior slot of a multi-slot entry and an empty slot. Such a mark does not affect any entry reserved at that slot later.
- R7: At most RETIRE_CAP entries retire per cycle. RETIRE_CAP = 0 removes the limit, so all SLOTS may retire in one cycle.
- R8: While an entry retires, its index appears on ret_idx, with lane 0 holding the oldest, and the matching ret_valid bit is 1. At that edge the head moves forward by the entry's slot count modulo SLOTS, and those slots are added back to free_slots.
- R9: A reservation and retirements at the same edge change free_slots by the sum of both: it goes down by the reserved count and up by the retired counts.
- R10: A mark presented in a cycle never retires its entry in that same cycle. The entry can retire from the next cycle on.
- R11: q_empty is 1 exactly when free_slots equals SLOTS. q_full is 1 exactly when free_slots is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Dispatch requests a reservation |
| rsv_idx | input | IDX_W | Instruction index stored in the entry |
| rsv_uops | input | UOP_W | Micro-op count of the instruction |
| rsv_ready | output | 1 | Enough free slots for the presented request |
| rsv_token | output | PTR_W | Token returned: the first slot of the new entry |
| exe_valid | input | 1 | An execution unit marks a token as executed |
| exe_token | input | PTR_W | Token being marked |
| ret_valid | output | LANES | Per-lane retire strobe, contiguous from lane 0 |
| ret_idx | output | LANES x IDX_W | Per-lane index of the instruction retiring |
| free_slots | output | CNT_W | Number of free slots |
| q_empty | output | 1 | Queue holds no entry |
| q_full | output | 1 | No free slot remains |

## Verification
The hardest situation to reach is a head entry that has not executed, with executed entries stacked behind it. Only that setup shows both in-order blocking and the difference between a limited and an unlimited retire width in a single cycle. The bench reaches it by reserving eight single-slot entries and marking them youngest first. The head is marked last, so in the following cycle the capped instance releases two entries and the unlimited one releases all eight. A long pseudo-random run then mixes clamped, refused and wrapping reservations with marks to arbitrary slots, against an arithmetic model of slot ownership.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Fill level of the retire queue
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } rsq_occ_e;

endpackage

// File: rtl/rsq_slot_store.sv
module rsq_slot_store #(
    parameter int SLOTS = 8,
    parameter int IDX_W = 8,
    parameter int CNT_W = 4,
    parameter int PTR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [PTR_W-1:0]                 wr_ptr,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [CNT_W-1:0]                 wr_cnt,
    input  logic                             mark_en,
    input  logic [PTR_W-1:0]                 mark_ptr,
    input  logic [SLOTS-1:0]                 clr_mask,
    output logic [SLOTS-1:0]                 occ,
    output logic [SLOTS-1:0]                 done,
    output logic [SLOTS-1:0][IDX_W-1:0]      idx_arr,
    output logic [SLOTS-1:0][CNT_W-1:0]      cnt_arr
);

    // Only the first slot of an entry carries a live bit; interior slots stay clear.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_wr;
        logic hit_mark;

        assign hit_wr   = wr_en && (wr_ptr == PTR_W'(s));
        assign hit_mark = mark_en && (mark_ptr == PTR_W'(s)) && occ[s] && !done[s];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[s]     <= 1'b0;
                done[s]    <= 1'b0;
                idx_arr[s] <= '0;
                cnt_arr[s] <= '0;
            end else if (hit_wr) begin
                occ[s]     <= 1'b1;
                done[s]    <= 1'b0;
                idx_arr[s] <= wr_idx;
                cnt_arr[s] <= wr_cnt;
            end else begin
                if (clr_mask[s]) begin
                    occ[s] <= 1'b0;
                end
                if (hit_mark) begin
                    done[s] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rsq_retire_scan.sv
module rsq_retire_scan #(
    parameter int SLOTS = 8,
    parameter int LANES = 2,
    parameter int IDX_W = 8,
    parameter int CNT_W = 4,
    parameter int PTR_W = 3
) (
    input  logic [PTR_W-1:0]                 head,
    input  logic [CNT_W-1:0]                 used,
    input  logic [SLOTS-1:0]                 occ,
    input  logic [SLOTS-1:0]                 done,
    input  logic [SLOTS-1:0][IDX_W-1:0]      idx_arr,
    input  logic [SLOTS-1:0][CNT_W-1:0]      cnt_arr,
    output logic [LANES-1:0]                 ret_valid,
    output logic [LANES-1:0][IDX_W-1:0]      ret_idx,
    output logic [SLOTS-1:0]                 clr_mask,
    output logic [CNT_W-1:0]                 freed,
    output logic [PTR_W-1:0]                 head_next
);

    localparam int SUM_W = CNT_W + 1;

    // Walk from the head, one lane per entry, stopping at the first unexecuted entry.
    always_comb begin
        logic [PTR_W-1:0] h;
        logic [CNT_W-1:0] left;
        logic [SUM_W-1:0] sum;
        logic             go;

        h         = head;
        left      = used;
        sum       = '0;
        go        = 1'b1;
        freed     = '0;
        clr_mask  = '0;
        ret_valid = '0;
        ret_idx   = '0;
        for (int k = 0; k < LANES; k++) begin
            if (go && (left != '0) && occ[h] && done[h]) begin
                ret_valid[k] = 1'b1;
                ret_idx[k]   = idx_arr[h];
                clr_mask[h]  = 1'b1;
                freed        = freed + cnt_arr[h];
                left         = left - cnt_arr[h];
                sum          = SUM_W'(h) + SUM_W'(cnt_arr[h]);
                if (sum >= SUM_W'(SLOTS)) begin
                    sum = sum - SUM_W'(SLOTS);
                end
                h = PTR_W'(sum);
            end else begin
                go = 1'b0;
            end
        end
        head_next = h;
    end

endmodule

// File: rtl/rsq_occupancy_fsm.sv
module rsq_occupancy_fsm
    import rsq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_en,
    input  logic [CNT_W-1:0] take_cnt,
    input  logic [CNT_W-1:0] give_cnt,
    output logic [CNT_W-1:0] free_cnt,
    output logic             q_empty,
    output logic             q_full
);

    rsq_occ_e         state_q;
    rsq_occ_e         state_d;
    logic [CNT_W-1:0] free_d;

    assign free_d = free_cnt - (take_en ? take_cnt : '0) + give_cnt;

    // Next-state selection with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (take_en) begin
                    // fill_whole or fill_start
                    state_d = (free_d == '0) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (free_d == '0) begin
                    state_d = OCC_FULL;          // fill_last
                end else if (free_d == CNT_W'(SLOTS)) begin
                    state_d = OCC_EMPTY;         // drain_last
                end
            end
            OCC_FULL: begin
                if (free_d == CNT_W'(SLOTS)) begin
                    state_d = OCC_EMPTY;         // drain_whole
                end else if (free_d != '0) begin
                    state_d = OCC_PARTIAL;       // drain_some
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= OCC_EMPTY;
            free_cnt <= CNT_W'(SLOTS);
        end else begin
            state_q  <= state_d;
            free_cnt <= free_d;
        end
    end

    // Flag decode
    always_comb begin
        q_empty = 1'b0;
        q_full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   q_empty = 1'b1;
            OCC_PARTIAL: q_empty = 1'b0;
            OCC_FULL:    q_full  = 1'b1;
            default:     q_empty = 1'b0;
        endcase
    end

endmodule

// File: rtl/rsq_retire_queue.sv
module rsq_retire_queue #(
    parameter int  SLOTS      = 8,
    parameter int  IDX_W      = 8,
    parameter int  UOP_W      = 4,
    parameter int  RETIRE_CAP = 2,
    localparam int PTR_W      = $clog2(SLOTS),
    localparam int CNT_W      = $clog2(SLOTS + 1),
    localparam int LANES      = (RETIRE_CAP == 0 || RETIRE_CAP > SLOTS) ? SLOTS : RETIRE_CAP
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rsv_valid,
    input  logic [IDX_W-1:0]            rsv_idx,
    input  logic [UOP_W-1:0]            rsv_uops,
    output logic                        rsv_ready,
    output logic [PTR_W-1:0]            rsv_token,
    input  logic                        exe_valid,
    input  logic [PTR_W-1:0]            exe_token,
    output logic [LANES-1:0]            ret_valid,
    output logic [LANES-1:0][IDX_W-1:0] ret_idx,
    output logic [CNT_W-1:0]            free_slots,
    output logic                        q_empty,
    output logic                        q_full
);

    localparam int SUM_W = CNT_W + 1;

    logic [PTR_W-1:0]              tail_q;
    logic [PTR_W-1:0]              head_q;
    logic [PTR_W-1:0]              head_d;
    logic [CNT_W-1:0]              need;
    logic [CNT_W-1:0]              used;
    logic [CNT_W-1:0]              freed;
    logic [SUM_W-1:0]              tail_sum;
    logic                          fire;
    logic [SLOTS-1:0]              occ;
    logic [SLOTS-1:0]              done;
    logic [SLOTS-1:0]              clr_mask;
    logic [SLOTS-1:0][IDX_W-1:0]   idx_arr;
    logic [SLOTS-1:0][CNT_W-1:0]   cnt_arr;

    // Slot count: micro-ops bounded to [1, SLOTS]
    always_comb begin
        if (rsv_uops == '0) begin
            need = CNT_W'(1);
        end else if (int'(rsv_uops) > SLOTS) begin
            need = CNT_W'(SLOTS);
        end else begin
            need = CNT_W'(rsv_uops);
        end
    end

    assign rsv_ready = (need <= free_slots);
    assign fire      = rsv_valid && rsv_ready;
    assign rsv_token = tail_q;
    assign used      = CNT_W'(SLOTS) - free_slots;

    always_comb begin
        tail_sum = SUM_W'(tail_q) + SUM_W'(need);
        if (tail_sum >= SUM_W'(SLOTS)) begin
            tail_sum = tail_sum - SUM_W'(SLOTS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
            head_q <= '0;
        end else begin
            if (fire) begin
                tail_q <= PTR_W'(tail_sum);
            end
            head_q <= head_d;
        end
    end

    rsq_slot_store #(
        .SLOTS (SLOTS),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .PTR_W (PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fire),
        .wr_ptr   (tail_q),
        .wr_idx   (rsv_idx),
        .wr_cnt   (need),
        .mark_en  (exe_valid),
        .mark_ptr (exe_token),
        .clr_mask (clr_mask),
        .occ      (occ),
        .done     (done),
        .idx_arr  (idx_arr),
        .cnt_arr  (cnt_arr)
    );

    rsq_retire_scan #(
        .SLOTS (SLOTS),
        .LANES (LANES),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .PTR_W (PTR_W)
    ) u_scan (
        .head      (head_q),
        .used      (used),
        .occ       (occ),
        .done      (done),
        .idx_arr   (idx_arr),
        .cnt_arr   (cnt_arr),
        .ret_valid (ret_valid),
        .ret_idx   (ret_idx),
        .clr_mask  (clr_mask),
        .freed     (freed),
        .head_next (head_d)
    );

    rsq_occupancy_fsm #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_en  (fire),
        .take_cnt (need),
        .give_cnt (freed),
        .free_cnt (free_slots),
        .q_empty  (q_empty),
        .q_full   (q_full)
    );

endmodule

// File: rtl/rsq_retire_queue_chk.sv
module rsq_retire_queue_chk #(
    parameter int SLOTS = 8,
    parameter int LANES = 2,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rsv_valid,
    input logic             rsv_ready,
    input logic [LANES-1:0] ret_valid,
    input logic [CNT_W-1:0] free_slots,
    input logic             q_empty,
    input logic             q_full
);

    assert_empty_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty == (free_slots == CNT_W'(SLOTS)));

    assert_full_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_full == (free_slots == '0));

    assert_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && !rsv_ready && ret_valid == '0) |=> $stable(free_slots));

    assert_takes_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && rsv_ready && ret_valid == '0) |=> (free_slots < $past(free_slots)));

    assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid & LANES'(ret_valid + 1'b1)) == '0);

    assert_quiet_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> (ret_valid == '0));

    assert_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid != '0 && !(rsv_valid && rsv_ready)) |=> (free_slots > $past(free_slots)));

endmodule

bind rsq_retire_queue rsq_retire_queue_chk #(
    .SLOTS (SLOTS),
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsv_valid  (rsv_valid),
    .rsv_ready  (rsv_ready),
    .ret_valid  (ret_valid),
    .free_slots (free_slots),
    .q_empty    (q_empty),
    .q_full     (q_full)
);

// File: tb/rsq_retire_queue_tb.sv
module rsq_retire_queue_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            rsv_valid = 1'b0;
    logic [7:0]      rsv_idx = '0;
    logic [3:0]      rsv_uops = '0;
    logic            exe_valid = 1'b0;
    logic [2:0]      exe_token = '0;

    logic            rdy_c, rdy_u;
    logic [2:0]      tok_c, tok_u;
    logic [1:0]      rv_c;
    logic [1:0][7:0] ri_c;
    logic [7:0]      rv_u;
    logic [7:0][7:0] ri_u;
    logic [3:0]      free_c, free_u;
    logic            emp_c, emp_u, full_c, full_u;

    rsq_retire_queue #(.SLOTS(8), .IDX_W(8), .UOP_W(4), .RETIRE_CAP(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_idx(rsv_idx),
        .rsv_uops(rsv_uops), .rsv_ready(rdy_c), .rsv_token(tok_c),
        .exe_valid(exe_valid), .exe_token(exe_token), .ret_valid(rv_c),
        .ret_idx(ri_c), .free_slots(free_c), .q_empty(emp_c), .q_full(full_c));

    rsq_retire_queue #(.SLOTS(8), .IDX_W(8), .UOP_W(4), .RETIRE_CAP(0)) u_dut_unl (
        .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_idx(rsv_idx),
        .rsv_uops(rsv_uops), .rsv_ready(rdy_u), .rsv_token(tok_u),
        .exe_valid(exe_valid), .exe_token(exe_token), .ret_valid(rv_u),
        .ret_idx(ri_u), .free_slots(free_u), .q_empty(emp_u), .q_full(full_u));

    int n_chk = 0;
    int n_fail = 0;

    // Arithmetic model of the capped instance
    int m_free, m_tail, m_head;
    int m_idx[8];
    int m_cnt[8];
    bit m_val[8];
    bit m_exe[8];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampu(input int u);
        if (u == 0) return 1;
        if (u > 8) return 8;
        return u;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rsv_valid = 1'b0; exe_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_free = 8; m_tail = 0; m_head = 0;
        for (int i = 0; i < 8; i++) begin
            m_val[i] = 1'b0; m_exe[i] = 1'b0; m_idx[i] = 0; m_cnt[i] = 0;
        end
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // Drive one cycle of stimulus, check outputs against the model, advance the model
    task automatic step(input bit rv, input int ridx, input int ru, input bit ev, input int et);
        int  need, h, used, n;
        bit  rdy, eok;
        @(negedge clk);
        rsv_valid = rv; rsv_idx = 8'(ridx); rsv_uops = 4'(ru);
        exe_valid = ev; exe_token = 3'(et);
        #1;
        chk(free_c == 4'(m_free), "R8 free_slots", free_c, m_free);
        chk(emp_c == (m_free == 8), "R11 q_empty", emp_c, m_free == 8);
        chk(full_c == (m_free == 0), "R11 q_full", full_c, m_free == 0);
        need = clampu(ru);
        rdy = (need <= m_free);
        chk(rdy_c == rdy, "R4 rsv_ready", rdy_c, rdy);
        chk(tok_c == 3'(m_tail), "R3 rsv_token", tok_c, m_tail);
        eok = ev && m_val[et] && !m_exe[et];
        h = m_head; used = 8 - m_free; n = 0;
        while (n < 2 && used > 0 && m_val[h] && m_exe[h]) begin
            chk(rv_c[n] == 1'b1, "R5 ret_valid lane", rv_c[n], 1);
            chk(ri_c[n] == 8'(m_idx[h]), "R8 ret_idx lane", ri_c[n], m_idx[h]);
            m_val[h] = 1'b0;
            m_free += m_cnt[h];
            used -= m_cnt[h];
            h = (h + m_cnt[h]) % 8;
            n++;
        end
        for (int k = n; k < 2; k++) begin
            chk(rv_c[k] == 1'b0, "R5 ret_valid idle lane", rv_c[k], 0);
        end
        m_head = h;
        if (rv && rdy) begin
            m_val[m_tail] = 1'b1; m_exe[m_tail] = 1'b0;
            m_idx[m_tail] = ridx & 255; m_cnt[m_tail] = need;
            m_tail = (m_tail + need) % 8;
            m_free -= need;
        end
        if (eok) m_exe[et] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lf;

        // R1: reset state
        do_reset();
        #1;
        chk(free_c == 4'd8, "R1 free_slots", free_c, 8);
        chk(emp_c == 1'b1, "R1 q_empty", emp_c, 1);
        chk(full_c == 1'b0, "R1 q_full", full_c, 0);
        chk(rv_c == 2'b00, "R1 ret_valid", rv_c, 0);
        chk(tok_c == 3'd0, "R1 rsv_token", tok_c, 0);

        // R2/R3: sweep every micro-op count
        for (int u = 0; u < 16; u++) begin
            do_reset();
            step(1, u, u, 0, 0);
            settle();
            chk(free_c == 4'(8 - clampu(u)), "R2 slots taken", free_c, 8 - clampu(u));
            chk(tok_c == 3'(clampu(u) % 8), "R3 tail wrap", tok_c, clampu(u) % 8);
        end

        // R4: refusal when the request does not fit
        do_reset();
        step(1, 1, 3, 0, 0);
        step(1, 2, 3, 0, 0);
        step(1, 3, 3, 0, 0);
        settle();
        chk(free_c == 4'd2, "R4 refused keeps free", free_c, 2);
        chk(tok_c == 3'd6, "R4 refused keeps tail", tok_c, 6);

        // R5: younger executed entry waits behind the head
        step(0, 0, 0, 1, 3);
        step(0, 0, 0, 0, 0);
        #1;
        chk(rv_c == 2'b00, "R5 blocked by head", rv_c, 0);
        // R6: interior slot mark ignored
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0);
        #1;
        chk(rv_c == 2'b00, "R6 interior mark ignored", rv_c, 0);
        // R10: mark on head not visible in the same cycle
        step(0, 0, 0, 1, 0);
        chk(rv_c == 2'b00, "R10 same-cycle mark", rv_c, 0);
        step(0, 0, 0, 0, 0);
        chk(rv_c == 2'b11, "R8 both retire", rv_c, 3);
        chk(ri_c[0] == 8'd1, "R8 oldest in lane 0", ri_c[0], 1);
        chk(ri_c[1] == 8'd2, "R8 younger in lane 1", ri_c[1], 2);
        settle();
        chk(free_c == 4'd8, "R8 slots returned", free_c, 8);

        // R6: mark on an empty slot does not pre-execute a later entry
        do_reset();
        step(0, 0, 0, 1, 0);
        step(1, 9, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(rv_c == 2'b00, "R6 empty-slot mark ignored", rv_c, 0);

        // R9: reserve and retire at one edge
        do_reset();
        step(1, 1, 2, 0, 0);
        step(0, 0, 0, 1, 0);
        step(1, 2, 3, 0, 0);
        chk(rv_c == 2'b01, "R9 retire pending", rv_c, 1);
        settle();
        chk(free_c == 4'd5, "R9 combined delta", free_c, 5);

        // R7: cap versus unlimited
        do_reset();
        for (int k = 0; k < 8; k++) step(1, 20 + k, 1, 0, 0);
        for (int k = 7; k >= 0; k--) step(0, 0, 0, 1, k);
        step(0, 0, 0, 0, 0);
        chk($countones(rv_c) == 2, "R7 capped lanes", $countones(rv_c), 2);
        chk($countones(rv_u) == 8, "R7 unlimited lanes", $countones(rv_u), 8);
        chk(ri_u[7] == 8'd27, "R7 unlimited youngest", ri_u[7], 27);
        settle();
        chk(emp_u == 1'b1, "R7 unlimited drained", emp_u, 1);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0);
        settle();
        chk(emp_c == 1'b1, "R7 capped drained", emp_c, 1);

        // Pseudo-random mixed traffic against the model
        do_reset();
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], int'(lf[15:8]), int'(lf[4:1]), lf[5] | lf[6], int'(lf[9:7]));
        end
        step(0, 0, 0, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule